// File: doc/BRIEF.md
# Pulse-Per-Second Generator from a Time-of-Day Counter

This block turns a disciplined time-of-day counter into a pulse-per-second output. The counter word carries whole seconds in its upper field and a fraction of a second in its lower field. The counter runs in the same 250 MHz clock domain as the block, so each count is 4 ns and no synchronizer sits on the counter input. Every time the fraction wraps and the seconds field moves to a new value, the block raises its PPS output on that clock edge. Because the edge comes from the counter itself and not from a local divider, the pulse stays locked in phase to network time after every servo correction or time step.

A rollover is recognised when the seconds field differs from its value in the previous cycle. Watching the seconds field avoids the half-second ambiguity of the fraction's top bit. On the rollover edge the block also emits a one-cycle tick strobe and captures the new seconds value. The PPS level then stays high for a programmable number of cycles. If the seconds field moves by anything other than +1, the block treats this as a step correction and raises a one-cycle step flag next to the single pulse. After reset the block stays quiet until it sees a real rollover, so it never emits a partial pulse at startup.

Top module: `tod_pps_gen`

## Requirements
- R1: While reset is asserted, and until the first rollover after it, `pps_o`, `tick_o` and `step_o` are 0 and `sec_o` is 0.
- R2: The seconds value present when reset is released is not a rollover. No pulse is produced until the seconds field changes from the first value the block samples.
- R3: The seconds field is `tod_i` bits [93:46]. When it differs from its value in the previous cycle, `pps_o` rises on the same clock edge at which the changed value is sampled.
- R4: `tick_o` is 1 for exactly one cycle, on the edge that raises `pps_o` for a rollover.
- R5: `sec_o` takes the new seconds value on the rollover edge and holds it until the next rollover.
- R6: `pps_o` stays high for exactly N cycles, where N is the value of `pulse_len_i` sampled on the rollover edge.
- R7: If `pulse_len_i` is 0 on the rollover edge, the width is the parameter `DEF_PW`. Its default is 25,000,000 cycles, which is 100 ms at 250 MHz.
- R8: A change of `pulse_len_i` while a pulse is high does not change the width of that pulse.
- R9: A change of the fraction field alone (`tod_i` bits [45:0], including its top bit 45) produces no pulse, no tick and no change of `sec_o`.
- R10: If the new seconds value is not the old value plus 1 (modulo 2^48), `step_o` is 1 for exactly one cycle together with `tick_o`, and only one pulse results. A wrap from all ones to zero counts as a normal +1.
- R11: A rollover that arrives while a pulse is still high restarts the pulse. The pulse then lasts the full width counted from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the counter is synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tod_i | input | 94 | Time-of-day word: seconds in [93:46], fraction in [45:0] |
| pulse_len_i | input | 32 | PPS high time in clock cycles; 0 selects DEF_PW |
| pps_o | output | 1 | Pulse-per-second level |
| tick_o | output | 1 | One-cycle strobe on each second boundary |
| step_o | output | 1 | One-cycle flag when the seconds field jumps by other than +1 |
| sec_o | output | 48 | Seconds value captured at the latest boundary |

## Verification
Every result is due one register stage after its cause. A seconds change driven before edge E shows up as `pps_o`, `tick_o`, `step_o` and `sec_o` right after E, and `tick_o` and `step_o` are back to 0 after E+1. A pulse of width N is high at N consecutive sample points, starting with the one after E. The bench drives inputs on falling edges and reads outputs on the following falling edge, so each check lands exactly one rising edge after its stimulus. Widths are counted one falling edge at a time until `pps_o` drops. Reset release is counted with the two-stage reset synchronizer taken into account.

// File: rtl/pps_pkg.sv
package pps_pkg;
  parameter int unsigned REF_CLK_HZ   = 250_000_000;
  parameter int unsigned PPS_DEF_CYC  = REF_CLK_HZ / 10;

  typedef struct packed {
    logic roll;
    logic step;
  } sec_evt_t;
endpackage

// File: rtl/sec_edge_det.sv
module sec_edge_det #(
  parameter int unsigned SEC_W = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEC_W-1:0]    sec_i,
  output pps_pkg::sec_evt_t   evt_o,
  output logic                tick_o,
  output logic                step_o,
  output logic [SEC_W-1:0]    sec_o
);
  logic             armed_q, armed_d;
  logic [SEC_W-1:0] prev_q, prev_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic             tick_q, step_q;
  logic [SEC_W-1:0] prev_inc;

  assign prev_inc = prev_q + SEC_W'(1);

  always_comb begin
    evt_o.roll = armed_q && (sec_i != prev_q);
    evt_o.step = evt_o.roll && (sec_i != prev_inc);
    armed_d    = 1'b1;
    prev_d     = sec_i;
    sec_d      = evt_o.roll ? sec_i : sec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= '0;
      sec_q   <= '0;
      tick_q  <= 1'b0;
      step_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      prev_q  <= prev_d;
      sec_q   <= sec_d;
      tick_q  <= evt_o.roll;
      step_q  <= evt_o.step;
    end
  end

  assign tick_o = tick_q;
  assign step_o = step_q;
  assign sec_o  = sec_q;
endmodule

// File: rtl/pps_stretch.sv
module pps_stretch #(
  parameter int unsigned PW_W   = 32,
  parameter int unsigned DEF_PW = pps_pkg::PPS_DEF_CYC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            roll_i,
  input  logic [PW_W-1:0] len_i,
  output logic            pps_o
);
  localparam logic [PW_W-1:0] DEF_LEN = PW_W'(DEF_PW);

  logic [PW_W-1:0] cnt_q, cnt_d;
  logic            pps_q, pps_d;
  logic [PW_W-1:0] eff_len;

  assign eff_len = (len_i == '0) ? DEF_LEN : len_i;

  always_comb begin
    cnt_d = cnt_q;
    pps_d = pps_q;
    if (roll_i) begin
      cnt_d = eff_len - PW_W'(1);
      pps_d = 1'b1;
    end else if (pps_q) begin
      if (cnt_q == '0) pps_d = 1'b0;
      else             cnt_d = cnt_q - PW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pps_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pps_q <= pps_d;
    end
  end

  assign pps_o = pps_q;
endmodule

// File: rtl/tod_pps_gen.sv
module tod_pps_gen #(
  parameter int unsigned SEC_W  = 48,
  parameter int unsigned FRAC_W = 46,
  parameter int unsigned PW_W   = 32,
  parameter int unsigned DEF_PW = pps_pkg::PPS_DEF_CYC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEC_W+FRAC_W-1:0] tod_i,
  input  logic [PW_W-1:0]         pulse_len_i,
  output logic                    pps_o,
  output logic                    tick_o,
  output logic                    step_o,
  output logic [SEC_W-1:0]        sec_o
);
  localparam int unsigned TOD_W = SEC_W + FRAC_W;

  logic              rst_q1, rst_ls_n;
  logic [SEC_W-1:0]  sec_field;
  logic              frac_unused;
  pps_pkg::sec_evt_t evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1   <= 1'b0;
      rst_ls_n <= 1'b0;
    end else begin
      rst_q1   <= 1'b1;
      rst_ls_n <= rst_q1;
    end
  end

  assign sec_field   = tod_i[TOD_W-1:FRAC_W];
  assign frac_unused = ^tod_i[FRAC_W-1:0];

  sec_edge_det #(.SEC_W(SEC_W)) u_det (
    .clk    (clk),
    .rst_n  (rst_ls_n),
    .sec_i  (sec_field),
    .evt_o  (evt),
    .tick_o (tick_o),
    .step_o (step_o),
    .sec_o  (sec_o)
  );

  pps_stretch #(.PW_W(PW_W), .DEF_PW(DEF_PW)) u_str (
    .clk    (clk),
    .rst_n  (rst_ls_n),
    .roll_i (evt.roll),
    .len_i  (pulse_len_i),
    .pps_o  (pps_o)
  );
endmodule

// File: rtl/tod_pps_chk.sv
module tod_pps_chk #(
  parameter int unsigned SEC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEC_W-1:0] sec_in,
  input logic             pps_o,
  input logic             tick_o,
  input logic             step_o,
  input logic [SEC_W-1:0] sec_o
);
  // R3
  pps_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pps_o) |-> tick_o);

  // R4
  tick_with_pps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> pps_o);

  // R5
  sec_latch_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (sec_o == $past(sec_in)));

  // R5
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |-> $stable(sec_o));

  // R10
  step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> tick_o);
endmodule

bind tod_pps_gen tod_pps_chk #(.SEC_W(SEC_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_ls_n),
  .sec_in (tod_i[SEC_W+FRAC_W-1:FRAC_W]),
  .pps_o  (pps_o),
  .tick_o (tick_o),
  .step_o (step_o),
  .sec_o  (sec_o)
);

// File: tb/tod_pps_gen_tb.sv
module tod_pps_gen_tb;
  localparam int CLK_PERIOD = 4;
  localparam int DEF_W      = 9;

  logic        clk;
  logic        rst_n;
  logic [47:0] sec;
  logic [45:0] frac;
  logic [31:0] plen;
  logic        pps, tick, step;
  logic [47:0] sec_q;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;

  tod_pps_gen #(.DEF_PW(DEF_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tod_i({sec, frac}), .pulse_len_i(plen),
    .pps_o(pps), .tick_o(tick), .step_o(step), .sec_o(sec_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // counts high cycles starting at the current sample point
  task automatic measure(output int w);
    w = 0;
    while (pps && w < 100) begin w++; cyc(); end
  endtask

  task automatic roll_to(input logic [47:0] s);
    sec = s; cyc();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sec = 48'd100; frac = '0; plen = 32'd4;
    repeat (3) cyc();
    chk("R1 pps in reset", pps, 0);
    chk("R1 tick in reset", tick, 0);
    chk("R1 step in reset", step, 0);
    chk("R1 sec in reset", sec_q, 0);
  endtask

  task automatic t_startup();
    int hi = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      frac = frac + 46'h1000_0000_0000; cyc();
      if (pps || tick) hi++;
    end
    chk("R2 no pulse before first rollover", hi, 0);
    chk("R1 sec stays zero", sec_q, 0);
  endtask

  task automatic t_rollover();
    int w;
    frac = '0;
    roll_to(48'd101);
    chk("R3 pps on rollover edge", pps, 1);
    chk("R4 tick on rollover edge", tick, 1);
    chk("R5 sec captured", sec_q, 101);
    chk("R10 no step for +1", step, 0);
    cyc();
    chk("R4 tick one cycle", tick, 0);
    chk("R5 sec held", sec_q, 101);
    measure(w);
    chk("R6 width 4 (remaining 3)", w, 3);
  endtask

  task automatic t_width();
    int w;
    plen = 32'd13; roll_to(48'd102); measure(w);
    chk("R6 width 13", w, 13);
    plen = 32'd1; roll_to(48'd103); measure(w);
    chk("R6 width 1", w, 1);
  endtask

  task automatic t_default();
    int w;
    plen = 32'd0; roll_to(48'd104); measure(w);
    chk("R7 default width", w, DEF_W);
  endtask

  task automatic t_len_change();
    int w;
    plen = 32'd5; roll_to(48'd105);
    plen = 32'd20; measure(w);
    chk("R8 width unaffected by len change", w, 5);
  endtask

  task automatic t_frac_only();
    int ev = 0;
    for (int i = 0; i < 10; i++) begin
      frac[45] = ~frac[45]; frac[10:0] = frac[10:0] + 11'd77; cyc();
      if (pps || tick || step) ev++;
    end
    chk("R9 fraction-only changes ignored", ev, 0);
    chk("R9 sec unchanged", sec_q, 105);
  endtask

  task automatic t_step();
    int w;
    plen = 32'd3;
    roll_to(48'd200);
    chk("R10 step forward flagged", step, 1);
    chk("R10 tick with step", tick, 1);
    chk("R5 sec after step", sec_q, 200);
    cyc();
    chk("R10 step one cycle", step, 0);
    measure(w);
    chk("R10 single pulse after step", w, 2);
    roll_to(48'd150);
    chk("R10 backward step flagged", step, 1);
    measure(w);
    roll_to(48'hFFFF_FFFF_FFFF); measure(w);
    roll_to(48'd0);
    chk("R10 wrap is not a step", step, 0);
    chk("R3 wrap rolls over", tick, 1);
    chk("R5 sec after wrap", sec_q, 0);
    measure(w);
  endtask

  task automatic t_retrigger();
    int w;
    plen = 32'd10; roll_to(48'd1);
    repeat (4) cyc();
    roll_to(48'd2);
    chk("R11 tick on retrigger", tick, 1);
    measure(w);
    chk("R11 full width after retrigger", w, 10);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_rollover();
    t_width();
    t_default();
    t_len_change();
    t_frac_only();
    t_step();
    t_retrigger();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule